// File: doc/BRIEF.md
# Timer Capture / Compare / PWM Channel

One channel of a general-purpose timer. It sits next to a free-running counter, reads the counter's current value and uses the counter's one-cycle wrap pulse. A four-bit configuration code selects the channel's behaviour. As an input capture, the channel stores the counter value on a chosen edge of the pin. As an output compare, it sets, clears or toggles the output pin when the counter reaches a programmed value. With toggle-on-wrap enabled, the same hardware produces PWM. The counter wrap marks the period boundary and the compare match marks the duty boundary.

A full-duty request bit holds the PWM output high for whole periods. The request is taken into effect only at a counter wrap. Setting it and clearing it therefore both take effect one period boundary later. Every capture or compare event raises a sticky event flag, which software clears through a strobe. A port-control output tells the surrounding pad logic when the channel is not driving the pin. While the pin is under port control, the channel holds its output at a preset level taken from the configuration code.

Top module: `tmr_chan`

## Requirements
- R1: After reset, pin_o=0, flag_o=0, cap_q=0 and cmp_q=0. The configuration code is 4'b0000, so port_ctl=1. Toggle-on-wrap and full-duty request are both 0.
- R2: The code is cfg_mode = {msb, msa, els[1:0]}. When els=00, port_ctl=1 and pin_o settles to the value of msa: 0 gives low, 1 gives high. This holds whatever msb is.
- R3: With {msb,msa}=00 the channel is an input capture. els=01 captures on rising pin edges only, 10 on falling edges only, and 11 on both. On a capture, cap_q loads cnt_val and flag_o sets. The pin passes through a two-flop synchronizer and a one-flop edge stage, so the pin change is seen three clock edges later.
- R4: flag_o stays set until flag_clr=1 is applied in a cycle with no new event. A clear and an event in the same cycle leave the flag set.
- R5: With {msb,msa} not 00 and els not 00, a compare match applies the els action: 01 toggles, 10 clears and 11 sets pin_o. Modes 01 and 1X behave alike. A match is counted only in a cycle where cnt_val equals cmp_q and differs from its value in the previous cycle, so holding the counter on the compare value acts once.
- R6: In an output mode with els not 00, cnt_ovf together with cfg_tov=1 toggles pin_o. In input capture mode cfg_tov has no effect on pin_o or on flag_o.
- R7: When cfg_tov=1 and a wrap and a compare match fall in the same cycle, only the wrap toggle is applied to the pin. The match still sets flag_o.
- R8: The full-duty override becomes active or inactive only on a cnt_ovf cycle. At that cycle it takes the value cfg_tov & cfg_max, and only in an output mode. While it is active, pin_o is 1.
- R9: In an output mode (msb or msa set), a compare match sets flag_o, whatever els is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | One-cycle counter wrap pulse |
| cfg_we | input | 1 | Write strobe for the code, toggle-on-wrap and full-duty bits |
| cfg_mode | input | 4 | Configuration code {msb, msa, els[1:0]} |
| cfg_tov | input | 1 | Toggle-on-wrap enable |
| cfg_max | input | 1 | Full-duty request |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| flag_clr | input | 1 | Event flag clear strobe |
| pin_i | input | 1 | Asynchronous pin input |
| cap_q | output | CNT_W | Captured counter value |
| cmp_q | output | CNT_W | Compare value readback |
| flag_o | output | 1 | Sticky event flag |
| pin_o | output | 1 | Channel output level |
| port_ctl | output | 1 | 1 when the pin is not driven by the channel |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a counter wrap and a compare match. The bench provokes this by setting the compare value to zero and wrapping the counter onto zero. It uses the clear-on-match action and starts from a low pin, so the wrap toggle (pin goes high) and the clear (pin stays low) give different results. The second pair is a flag clear and a compare event: the bench drives the clear strobe in the same cycle the counter steps onto the compare value, and expects the flag still set afterwards.

// File: rtl/tmr_chan_pkg.sv
// Package: shared types and mode decoding for the timer channel.
// Assumes the code layout {msb, msa, els[1:0]}.
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } cmp_act_e;

    typedef struct packed {
        logic       msb;
        logic       msa;
        logic [1:0] els;
    } chan_mode_t;

    function automatic logic mode_is_capture(chan_mode_t m);
        return !m.msb && !m.msa;
    endfunction

    function automatic logic mode_is_output(chan_mode_t m);
        return m.msb || m.msa;
    endfunction

endpackage

// File: rtl/tmr_chan_edge.sv
// Module: pin synchronizer and edge detector.
// Assumes pin_i is asynchronous. It is sampled through SYNC_STAGES flops,
// then compared with one more delayed flop to find edges.
module tmr_chan_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise,
    output logic fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;

    // Shift the pin through the synchronizer and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], pin_i};
            prev_q <= sync_q[TOP];
        end
    end

    // Edge decode from the current and previous synchronized samples.
    always_comb begin
        rise = sync_q[TOP] & ~prev_q;
        fall = ~sync_q[TOP] & prev_q;
    end

    // R3: a rising edge can never be seen in two consecutive cycles.
    p_edge_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tmr_chan_cmp.sv
// Module: compare register and match detector.
// Assumes the counter may stall. A match is reported only in a cycle where
// the counter differs from its previous value.
module tmr_chan_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_q,
    output logic             match
);
    logic [CNT_W-1:0] cnt_prev;

    // Hold the compare value and the previous counter sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            cnt_prev <= '0;
        end else begin
            cnt_prev <= cnt_val;
            if (cmp_we) cmp_q <= cmp_wdata;
        end
    end

    // Equality match, qualified by a counter change.
    always_comb match = (cnt_val == cmp_q) && (cnt_val != cnt_prev);

    // R5: with the counter standing still, a match is not repeated.
    p_match_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $stable(cmp_q)) |=> (!match || cnt_val != $past(cnt_val)));

endmodule

// File: rtl/tmr_chan_out.sv
// Module: output pin state, wrap toggle and full-duty override.
// Assumes mode, tov and max_req are registered settings. The wrap and match
// inputs are single-cycle qualifiers.
module tmr_chan_out
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_mode_t mode,
    input  logic       tov,
    input  logic       max_req,
    input  logic       ovf,
    input  logic       match,
    output logic       pin_o
);
    logic     out_q;
    logic     max_act;
    logic     is_out;
    cmp_act_e act;

    always_comb begin
        is_out = mode_is_output(mode);
        act    = cmp_act_e'(mode.els);
    end

    // Pin state: preset, then wrap toggle, then the compare action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (act == ACT_NONE) begin
            out_q <= mode.msa;
        end else if (is_out) begin
            if (ovf && tov) begin
                out_q <= ~out_q;
            end else if (match) begin
                case (act)
                    ACT_TOGGLE: out_q <= ~out_q;
                    ACT_CLEAR:  out_q <= 1'b0;
                    ACT_SET:    out_q <= 1'b1;
                    default:    out_q <= out_q;
                endcase
            end
        end
    end

    // Full-duty override changes only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)   max_act <= 1'b0;
        else if (ovf) max_act <= tov & max_req & is_out;
    end

    // Drive the pin, forcing it high while the override is active.
    always_comb pin_o = out_q | max_act;

    // R2: with no pin action selected the level follows msa.
    p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE) |=> (out_q == $past(mode.msa)));
    // R7: a wrap with toggling enabled always flips the pin state.
    p_ovf_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_out && act != ACT_NONE && ovf && tov) |=> (out_q != $past(out_q)));
    // R8: the override state is frozen between wraps.
    p_max_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> (max_act == $past(max_act)));

endmodule

// File: rtl/tmr_chan.sv
// Module: timer capture/compare/PWM channel top.
// Holds the settings, the capture register and the sticky event flag.
// Assumes the counter and its wrap pulse are supplied by a neighbour.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_mode,
    input  logic             cfg_tov,
    input  logic             cfg_max,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    input  logic             pin_i,
    output logic [CNT_W-1:0] cap_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_o,
    output logic             pin_o,
    output logic             port_ctl
);
    chan_mode_t mode_q;
    logic       tov_q;
    logic       max_q;
    logic       rise, fall, match;
    logic       cap_evt, cmp_evt;

    // Settings register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tov_q  <= 1'b0;
            max_q  <= 1'b0;
        end else if (cfg_we) begin
            mode_q <= chan_mode_t'(cfg_mode);
            tov_q  <= cfg_tov;
            max_q  <= cfg_max;
        end
    end

    tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise(rise), .fall(fall)
    );

    tmr_chan_cmp #(.CNT_W(CNT_W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .cmp_q(cmp_q), .match(match)
    );

    tmr_chan_out i_out (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .tov(tov_q), .max_req(max_q),
        .ovf(cnt_ovf), .match(match), .pin_o(pin_o)
    );

    // Event qualification per mode.
    always_comb begin
        cap_evt  = mode_is_capture(mode_q) &&
                   ((mode_q.els[0] && rise) || (mode_q.els[1] && fall));
        cmp_evt  = mode_is_output(mode_q) && match;
        port_ctl = (mode_q.els == 2'b00) || mode_is_capture(mode_q);
    end

    // Capture register and sticky flag. A new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (cap_evt) cap_q <= cnt_val;
            if (cap_evt || cmp_evt) flag_o <= 1'b1;
            else if (flag_clr)      flag_o <= 1'b0;
        end
    end

    // R3: a capture stores the counter value of the event cycle.
    p_cap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(cnt_val)));
    // R4: the flag holds without a clear.
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr) |=> flag_o);
    // R4: a clear with no event drops the flag.
    p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_evt && !cmp_evt) |=> !flag_o);
    // R9: an output-mode match raises the flag.
    p_cmp_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> flag_o);

endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_ovf = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = '0;
    logic        cfg_tov = 1'b0;
    logic        cfg_max = 1'b0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        pin_i = 1'b0;
    logic [15:0] cap_q, cmp_q;
    logic        flag_o, pin_o, port_ctl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    string       q_req[$];
    int          q_kind[$];
    logic [31:0] q_exp[$];

    always #2 clk = ~clk;

    tmr_chan i_tmr_chan (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_tov(cfg_tov), .cfg_max(cfg_max),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr), .pin_i(pin_i),
        .cap_q(cap_q), .cmp_q(cmp_q), .flag_o(flag_o), .pin_o(pin_o),
        .port_ctl(port_ctl)
    );

    // Driver side: push an expected item (0 pin, 1 flag, 2 cap, 3 port, 4 cmp).
    task automatic expect_v(string req, int kind, logic [31:0] v);
        q_req.push_back(req);
        q_kind.push_back(kind);
        q_exp.push_back(v);
    endtask

    // Monitor: compares queued items shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                automatic string       r = q_req.pop_front();
                automatic int          k = q_kind.pop_front();
                automatic logic [31:0] e = q_exp.pop_front();
                automatic logic [31:0] a;
                case (k)
                    0:       a = {31'd0, pin_o};
                    1:       a = {31'd0, flag_o};
                    2:       a = {16'd0, cap_q};
                    3:       a = {31'd0, port_ctl};
                    default: a = {16'd0, cmp_q};
                endcase
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s item %0d actual=%h expected=%h", r, k, a, e);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(logic [3:0] m, logic t, logic x);
        cfg_mode = m; cfg_tov = t; cfg_max = x; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        step(1);
    endtask

    task automatic cnt_set(logic [15:0] v, logic o);
        cnt_val = v; cnt_ovf = o;
        step(1);
        cnt_ovf = 1'b0;
    endtask

    task automatic set_cmp(logic [15:0] v);
        cmp_wdata = v; cmp_we = 1'b1;
        step(1);
        cmp_we = 1'b0;
    endtask

    task automatic pin_set(logic b);
        pin_i = b;
        step(4);
    endtask

    task automatic clr();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_v("R1", 0, 0); expect_v("R1", 1, 0); expect_v("R1", 2, 0);
        expect_v("R1", 3, 1); expect_v("R1", 4, 0);

        // R2 preset levels
        cfg(4'b0100, 0, 0); expect_v("R2", 0, 1); expect_v("R2", 3, 1);
        cfg(4'b1000, 0, 0); expect_v("R2", 0, 0);
        cfg(4'b1100, 0, 0); expect_v("R2", 0, 1);
        cfg(4'b0000, 0, 0); expect_v("R2", 0, 0);

        // R3 capture edges
        cnt_set(16'h1234, 0);
        cfg(4'b0001, 0, 0); clr();
        pin_set(1); expect_v("R3", 1, 1); expect_v("R3", 2, 16'h1234);
        expect_v("R3", 3, 1);
        clr(); cnt_set(16'h2222, 0);
        pin_set(0); expect_v("R3", 1, 0); expect_v("R3", 2, 16'h1234);
        cfg(4'b0010, 0, 0); clr();
        pin_set(1); expect_v("R3", 1, 0); expect_v("R3", 2, 16'h1234);
        cnt_set(16'h3333, 0);
        pin_set(0); expect_v("R3", 1, 1); expect_v("R3", 2, 16'h3333);
        clr(); cfg(4'b0011, 0, 0); cnt_set(16'h4444, 0);
        pin_set(1); expect_v("R3", 1, 1); expect_v("R3", 2, 16'h4444);
        clr(); cnt_set(16'h5555, 0);
        pin_set(0); expect_v("R3", 1, 1); expect_v("R3", 2, 16'h5555);
        clr();

        // R5 and R9 compare actions
        set_cmp(16'h0080); expect_v("R5", 4, 16'h0080);
        cfg(4'b0100, 0, 0); expect_v("R5", 0, 1);
        cfg(4'b0110, 0, 0); expect_v("R5", 3, 0);
        cnt_set(16'h007F, 0); expect_v("R5", 0, 1);
        cnt_set(16'h0080, 0); expect_v("R5", 0, 0); expect_v("R9", 1, 1);
        clr(); step(3); expect_v("R5", 1, 0);
        cfg(4'b0111, 0, 0); cnt_set(16'h0081, 0); cnt_set(16'h0080, 0);
        expect_v("R5", 0, 1);
        cfg(4'b0101, 0, 0); cnt_set(16'h0081, 0); cnt_set(16'h0080, 0);
        expect_v("R5", 0, 0);
        step(2); expect_v("R5", 0, 0);
        cnt_set(16'h0081, 0); cnt_set(16'h0080, 0); expect_v("R5", 0, 1);
        cfg(4'b1010, 0, 0); cnt_set(16'h0081, 0); cnt_set(16'h0080, 0);
        expect_v("R5", 0, 0);

        // R4 clear and event in the same cycle
        clr(); expect_v("R4", 1, 0);
        cnt_set(16'h0081, 0);
        flag_clr = 1'b1; cnt_set(16'h0080, 0); flag_clr = 1'b0;
        expect_v("R4", 1, 1);
        clr(); expect_v("R4", 1, 0);

        // R6 toggle on wrap, and no effect in capture mode
        cfg(4'b1000, 0, 0);
        cfg(4'b0101, 1, 0); cnt_set(16'h0010, 0);
        cnt_set(16'h0000, 1); expect_v("R6", 0, 1);
        cnt_set(16'h0010, 0); cnt_set(16'h0000, 1); expect_v("R6", 0, 0);
        cfg(4'b0001, 1, 0); cnt_set(16'h0010, 0); cnt_set(16'h0000, 1);
        expect_v("R6", 0, 0); expect_v("R6", 1, 0);

        // R7 wrap beats a simultaneous compare clear
        cfg(4'b1000, 0, 0); set_cmp(16'h0000);
        cfg(4'b0110, 1, 0); cnt_set(16'h0010, 0);
        cnt_set(16'h0000, 1); expect_v("R7", 0, 1); expect_v("R7", 1, 1);
        clr();

        // R8 full-duty override with one-period latency
        set_cmp(16'h0080); cfg(4'b0110, 1, 0);
        cnt_set(16'h0080, 0); expect_v("R8", 0, 0);
        cnt_set(16'h0000, 1); expect_v("R8", 0, 1);
        cnt_set(16'h0080, 0); expect_v("R8", 0, 0);
        cfg(4'b0110, 1, 1); expect_v("R8", 0, 0);
        cnt_set(16'h0000, 1); expect_v("R8", 0, 1);
        cnt_set(16'h0080, 0); expect_v("R8", 0, 1);
        cnt_set(16'h0000, 1);
        cfg(4'b0110, 1, 0);
        cnt_set(16'h0080, 0); expect_v("R8", 0, 1);
        cnt_set(16'h0000, 1); expect_v("R8", 0, 1);
        cnt_set(16'h0080, 0); expect_v("R8", 0, 0);
        cfg(4'b0110, 0, 1); cnt_set(16'h0000, 1); expect_v("R8", 0, 0);

        step(3);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule